// File: doc/BRIEF.md
# Subnormal operand normalizer

This block takes a single-precision (binary32) operand and unpacks it into an internal form in which every finite nonzero value carries a leading one. The internal exponent is two bits wider than the architectural field. A subnormal input can therefore be given its true exponent, below the smallest normal one, and held with its top significand bit set. Downstream arithmetic then only ever sees normalized significands, plus four class flags for the special encodings.

Normal, zero, infinity and NaN encodings take the fast path and produce their result one cycle after acceptance. A subnormal input needs a leading-zero count and a left shift, and these take one extra pipeline cycle. During that cycle the block drops its ready signal, so results always leave in arrival order. A flush-to-zero control bit, sampled with each operand, turns a subnormal encoding into a signed zero on the fast path. An assist pulse marks every subnormal that is actually normalized.

The control is a two-state machine. In state `ST_PASS` the block accepts operands. The transition `ST_PASS -> ST_SHIFT` is taken when an unflushed subnormal is accepted. In state `ST_SHIFT` the block performs the normalization and accepts nothing. The transition `ST_SHIFT -> ST_PASS` is taken unconditionally after one cycle. Reset enters `ST_PASS`.

Top module: `fp_unpack_norm`

## Requirements
- R1: A normal input (exponent field 1..254) is accepted while in_ready is high and yields out_valid in the next cycle. Its output has out_sig = {1, fraction}, out_exp = field - 127 as a 10-bit two's complement value, out_sign equal to bit 31, and all four class flags low.
- R2: A subnormal input (field 0, fraction nonzero) with in_ftz low is normalized as follows. Let k be the number of leading zeros of the 24-bit value {0, fraction}. The block outputs out_sig = {0, fraction} shifted left by k, which makes bit 23 one, and out_exp = -126 - k. It sets out_sub high and the other flags low.
- R3: A subnormal input with in_ftz low produces its result two cycles after acceptance. In the cycle between acceptance and result, in_ready and out_valid are both low, and in_ready is high again in the following cycle.
- R4: A subnormal input with in_ftz high yields a result one cycle after acceptance. That result keeps the input sign and has out_zero high, out_sub low, out_exp = -127 and out_sig = 0. in_ftz has no effect on any other encoding.
- R5: A zero input (field 0, fraction 0) yields, one cycle later, out_zero high, out_exp = -127 and out_sig = 0, with the sign kept.
- R6: Field 255 with a zero fraction yields out_inf. Field 255 with a nonzero fraction yields out_nan. Both give out_exp = 128 and out_sig = {1, fraction}, one cycle after acceptance.
- R7: Results leave in acceptance order. An operand held on in_valid while in_ready is low is not taken and produces no result until it is accepted.
- R8: subnormal_seen is high for exactly the one cycle after an unflushed subnormal is accepted. It is never high at any other time, including for flushed subnormals.
- R9: out_valid is low in any cycle that follows a cycle with no acceptance while in state `ST_PASS`. At most one class flag is high with out_valid.
- R10: While reset (rst_n low, synchronous) is applied, and right after it, out_valid and subnormal_seen are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_ready | output | 1 | Operand taken when high together with in_valid |
| in_op | input | 32 | Raw binary32 operand |
| in_ftz | input | 1 | Flush subnormal encodings to zero |
| out_valid | output | 1 | Result strobe |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | 10 | Unbiased exponent, two's complement |
| out_sig | output | 24 | Significand with the leading bit at bit 23 |
| out_zero | output | 1 | Result is a signed zero |
| out_sub | output | 1 | Result came from a normalized subnormal |
| out_inf | output | 1 | Result is an infinity |
| out_nan | output | 1 | Result is a NaN |
| subnormal_seen | output | 1 | One-cycle pulse for an unflushed subnormal |

## Verification
The bench sweeps all 256 exponent field values against several fraction patterns (zero, a lone low bit, a lone high bit, alternating bits, all ones), under both signs and both flush settings. This separates the fast and slow paths, zero from subnormal, and infinity from NaN. A single one walked through each of the 23 fraction positions gives every shift distance from 1 to 23, which exposes any error in the leading-zero count or in the exponent adjustment. A streamed normal-subnormal-normal sequence with the third operand held during the stall shows that order is kept and that nothing is taken while ready is low.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    // Control states of the normalizer
    typedef enum logic [0:0] {
        ST_PASS  = 1'b0,   // accepting operands, fast results
        ST_SHIFT = 1'b1    // normalizing a held subnormal
    } norm_state_t;

    // Raw encoding classes seen on the input
    typedef struct packed {
        logic zero;
        logic sub;
        logic inf;
        logic nan;
    } fp_class_t;

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
    import fpn_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int OP_W  = EXP_W + FRAC_W + 1
) (
    input  logic [OP_W-1:0]   op,
    output logic              sign,
    output logic [EXP_W-1:0]  field,
    output logic [FRAC_W-1:0] frac,
    output fp_class_t         cls
);

    logic field_min;
    logic field_max;
    logic frac_nz;

    always_comb begin
        sign      = op[OP_W-1];
        field     = op[OP_W-2:FRAC_W];
        frac      = op[FRAC_W-1:0];
        field_min = (field == '0);
        field_max = (field == '1);
        frac_nz   = (frac != '0);
        cls.zero  = field_min & ~frac_nz;
        cls.sub   = field_min &  frac_nz;
        cls.inf   = field_max & ~frac_nz;
        cls.nan   = field_max &  frac_nz;
    end

endmodule

// File: rtl/fpn_lzc.sv
module fpn_lzc #(
    parameter int W  = 24,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    logic found;

    always_comb begin
        cnt   = CW'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                cnt   = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpn_lshift.sv
module fpn_lshift #(
    parameter int W  = 24,
    parameter int SW = 5
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stage [0:SW];

    assign stage[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        assign stage[i+1] = amt[i] ? (stage[i] << (2 ** i)) : stage[i];
    end

    assign dout = stage[SW];

endmodule

// File: rtl/fpn_ctrl.sv
module fpn_ctrl
    import fpn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_slow,
    output logic in_ready,
    output logic shift_en
);

    norm_state_t state;
    norm_state_t state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PASS;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx = state;
        in_ready = 1'b0;
        shift_en = 1'b0;
        unique case (state)
            ST_PASS: begin
                in_ready = 1'b1;
                if (accept_slow) begin
                    state_nx = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                shift_en = 1'b1;
                state_nx = ST_PASS;
            end
            default: begin
                state_nx = ST_PASS;
            end
        endcase
    end

endmodule

// File: rtl/fp_unpack_norm.sv
module fp_unpack_norm
    import fpn_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int IEXP_W = 10,
    localparam int OP_W  = EXP_W + FRAC_W + 1,
    localparam int SIG_W = FRAC_W + 1,
    localparam int LZ_W  = $clog2(SIG_W + 1),
    localparam int BIAS  = (2 ** (EXP_W - 1)) - 1,
    localparam int EMIN  = 1 - BIAS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic              in_ftz,
    output logic              out_valid,
    output logic              out_sign,
    output logic [IEXP_W-1:0] out_exp,
    output logic [SIG_W-1:0]  out_sig,
    output logic              out_zero,
    output logic              out_sub,
    output logic              out_inf,
    output logic              out_nan,
    output logic              subnormal_seen
);

    // Input decode
    logic              raw_sign;
    logic [EXP_W-1:0]  raw_field;
    logic [FRAC_W-1:0] raw_frac;
    fp_class_t         raw_cls;

    fpn_classify #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_cls (
        .op    (in_op),
        .sign  (raw_sign),
        .field (raw_field),
        .frac  (raw_frac),
        .cls   (raw_cls)
    );

    // Handshake and path selection
    logic accept;
    logic accept_slow;
    logic accept_fast;
    logic shift_en;

    assign accept      = in_valid & in_ready;
    assign accept_slow = accept & raw_cls.sub & ~in_ftz;
    assign accept_fast = accept & ~accept_slow;

    fpn_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_slow (accept_slow),
        .in_ready    (in_ready),
        .shift_en    (shift_en)
    );

    // Fast path result
    logic              fast_zero;
    logic [IEXP_W-1:0] fast_exp;
    logic [SIG_W-1:0]  fast_sig;

    always_comb begin
        fast_zero = raw_cls.zero | (raw_cls.sub & in_ftz);
        fast_exp  = IEXP_W'(int'(raw_field) - BIAS);
        fast_sig  = fast_zero ? '0 : {1'b1, raw_frac};
    end

    // Slow path: held subnormal, normalized in the extra cycle
    logic              hold_sign;
    logic [FRAC_W-1:0] hold_frac;
    logic [SIG_W-1:0]  hold_sig;
    logic [LZ_W-1:0]   lz_cnt;
    logic [SIG_W-1:0]  norm_sig;
    logic [IEXP_W-1:0] norm_exp;

    assign hold_sig = {1'b0, hold_frac};

    fpn_lzc #(
        .W (SIG_W)
    ) u_lzc (
        .vec (hold_sig),
        .cnt (lz_cnt)
    );

    fpn_lshift #(
        .W  (SIG_W),
        .SW (LZ_W)
    ) u_shift (
        .din  (hold_sig),
        .amt  (lz_cnt),
        .dout (norm_sig)
    );

    assign norm_exp = IEXP_W'(EMIN - int'(lz_cnt));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_sign <= 1'b0;
            hold_frac <= '0;
        end else if (accept_slow) begin
            hold_sign <= raw_sign;
            hold_frac <= raw_frac;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_sign       <= 1'b0;
            out_exp        <= '0;
            out_sig        <= '0;
            out_zero       <= 1'b0;
            out_sub        <= 1'b0;
            out_inf        <= 1'b0;
            out_nan        <= 1'b0;
            subnormal_seen <= 1'b0;
        end else begin
            out_valid      <= 1'b0;
            subnormal_seen <= accept_slow;
            if (shift_en) begin
                out_valid <= 1'b1;
                out_sign  <= hold_sign;
                out_exp   <= norm_exp;
                out_sig   <= norm_sig;
                out_zero  <= 1'b0;
                out_sub   <= 1'b1;
                out_inf   <= 1'b0;
                out_nan   <= 1'b0;
            end else if (accept_fast) begin
                out_valid <= 1'b1;
                out_sign  <= raw_sign;
                out_exp   <= fast_exp;
                out_sig   <= fast_sig;
                out_zero  <= fast_zero;
                out_sub   <= 1'b0;
                out_inf   <= raw_cls.inf;
                out_nan   <= raw_cls.nan;
            end
        end
    end

endmodule

// File: rtl/fpn_chk.sv
module fpn_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int IEXP_W = 10,
    localparam int OP_W  = EXP_W + FRAC_W + 1,
    localparam int SIG_W = FRAC_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [OP_W-1:0]   in_op,
    input logic              in_ftz,
    input logic              out_valid,
    input logic              out_sign,
    input logic [IEXP_W-1:0] out_exp,
    input logic [SIG_W-1:0]  out_sig,
    input logic              out_zero,
    input logic              out_sub,
    input logic              out_inf,
    input logic              out_nan,
    input logic              subnormal_seen
);

    logic in_is_sub;
    logic take_slow;
    logic take_flush;
    logic take_fast;

    assign in_is_sub  = (in_op[OP_W-2:FRAC_W] == '0) && (in_op[FRAC_W-1:0] != '0);
    assign take_slow  = in_valid && in_ready && in_is_sub && !in_ftz;
    assign take_flush = in_valid && in_ready && in_is_sub && in_ftz;
    assign take_fast  = in_valid && in_ready && !(in_is_sub && !in_ftz);

    a_r1_fast_latency: assert property (@(posedge clk) disable iff (!rst_n)
        take_fast |=> out_valid);

    a_r2_leading_one: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sub) |-> out_sig[SIG_W-1]);

    a_r3_stall_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        take_slow |=> (!in_ready && !out_valid));

    a_r3_resume: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (in_ready && out_valid && out_sub));

    a_r4_flush: assert property (@(posedge clk) disable iff (!rst_n)
        take_flush |=> (out_valid && out_zero && !out_sub && !subnormal_seen && out_sig == '0));

    a_r8_seen_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_slow |=> subnormal_seen);

    a_r8_seen_only: assert property (@(posedge clk) disable iff (!rst_n)
        subnormal_seen |-> !in_ready);

    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !out_valid);

    a_r9_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({out_zero, out_sub, out_inf, out_nan}));

endmodule

bind fp_unpack_norm fpn_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .IEXP_W (IEXP_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_op          (in_op),
    .in_ftz         (in_ftz),
    .out_valid      (out_valid),
    .out_sign       (out_sign),
    .out_exp        (out_exp),
    .out_sig        (out_sig),
    .out_zero       (out_zero),
    .out_sub        (out_sub),
    .out_inf        (out_inf),
    .out_nan        (out_nan),
    .subnormal_seen (subnormal_seen)
);

// File: tb/sim_fp_unpack_norm.sv
`timescale 1ns/1ps
module sim_fp_unpack_norm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_op = '0;
    logic        in_ftz = 1'b0;
    logic        out_valid;
    logic        out_sign;
    logic [9:0]  out_exp;
    logic [23:0] out_sig;
    logic        out_zero;
    logic        out_sub;
    logic        out_inf;
    logic        out_nan;
    logic        subnormal_seen;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fp_unpack_norm u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_op          (in_op),
        .in_ftz         (in_ftz),
        .out_valid      (out_valid),
        .out_sign       (out_sign),
        .out_exp        (out_exp),
        .out_sig        (out_sig),
        .out_zero       (out_zero),
        .out_sub        (out_sub),
        .out_inf        (out_inf),
        .out_nan        (out_nan),
        .subnormal_seen (subnormal_seen)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Packed expected result: sign, exp[9:0], sig[23:0], zero, sub, inf, nan
    function automatic logic [38:0] model(input logic [31:0] op, input logic ftz);
        logic [7:0]  e;
        logic [22:0] f;
        logic        s;
        int          msb;
        int          k;
        e = op[30:23];
        f = op[22:0];
        s = op[31];
        if (e == 8'd255) begin
            model = {s, 10'(128), 1'b1, f, 1'b0, 1'b0, (f == 0), (f != 0)};
        end else if (e == 8'd0 && (f == 0 || ftz)) begin
            model = {s, 10'(-127), 24'd0, 4'b1000};
        end else if (e == 8'd0) begin
            msb = 0;
            for (int i = 0; i < 23; i++) if (f[i]) msb = i;
            k = 23 - msb;
            model = {s, 10'(-126 - k), 24'({1'b0, f} << k), 4'b0100};
        end else begin
            model = {s, 10'(int'(e) - 127), 1'b1, f, 4'b0000};
        end
    endfunction

    function automatic string tag_of(input logic [31:0] op, input logic ftz);
        if (op[30:23] == 8'd255) return "R6";
        if (op[30:23] == 8'd0 && op[22:0] == 0) return "R5";
        if (op[30:23] == 8'd0 && ftz) return "R4";
        if (op[30:23] == 8'd0) return "R2";
        return "R1";
    endfunction

    function automatic logic [38:0] got();
        return {out_sign, out_exp, out_sig, out_zero, out_sub, out_inf, out_nan};
    endfunction

    task automatic apply(input logic [31:0] op, input logic ftz);
        logic slow;
        slow = (op[30:23] == 8'd0) && (op[22:0] != 0) && !ftz;
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_ftz   = ftz;
        check("R7 ready before accept", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        if (slow) begin
            check("R3 ready low in extra cycle", 64'(in_ready), 64'd0);
            check("R3 no output in extra cycle", 64'(out_valid), 64'd0);
            check("R8 assist pulse", 64'(subnormal_seen), 64'd1);
            @(negedge clk);
            check("R3 ready restored", 64'(in_ready), 64'd1);
        end
        check("R8 no pulse on result cycle", 64'(subnormal_seen), 64'd0);
        check({tag_of(op, ftz), " valid"}, 64'(out_valid), 64'd1);
        check({tag_of(op, ftz), " result"}, 64'(got()), 64'(model(op, ftz)));
        @(negedge clk);
        check("R9 idle no output", 64'(out_valid), 64'd0);
    endtask

    initial begin
        logic [22:0] fr [5];
        fr[0] = 23'h000000;
        fr[1] = 23'h000001;
        fr[2] = 23'h400000;
        fr[3] = 23'h2AAAAA;
        fr[4] = 23'h7FFFFF;

        repeat (3) @(negedge clk);
        check("R10 reset out_valid", 64'(out_valid), 64'd0);
        check("R10 reset in_ready", 64'(in_ready), 64'd1);
        check("R10 reset subnormal_seen", 64'(subnormal_seen), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset out_valid", 64'(out_valid), 64'd0);
        check("R10 after reset in_ready", 64'(in_ready), 64'd1);

        // Exponent sweep against fraction patterns, signs and flush modes
        for (int e = 0; e < 256; e++)
            for (int j = 0; j < 5; j++)
                for (int s = 0; s < 2; s++)
                    for (int z = 0; z < 2; z++)
                        apply({s[0], e[7:0], fr[j]}, z[0]);

        // Walking one through the fraction: every shift distance (R2, R4)
        for (int b = 0; b < 23; b++)
            for (int z = 0; z < 2; z++)
                apply({1'b0, 8'd0, 23'(1) << b}, z[0]);

        // Ordering with an operand held through the stall (R7)
        @(negedge clk);
        in_valid = 1'b1; in_ftz = 1'b0; in_op = 32'h3F800000;
        @(negedge clk);
        check("R7 first result", 64'(got()), 64'(model(32'h3F800000, 1'b0)));
        in_op = 32'h00000001;
        @(negedge clk);
        check("R7 stall ready", 64'(in_ready), 64'd0);
        check("R7 stall no output", 64'(out_valid), 64'd0);
        in_op = 32'hC0400000;
        @(negedge clk);
        check("R7 second valid", 64'(out_valid), 64'd1);
        check("R7 second result", 64'(got()), 64'(model(32'h00000001, 1'b0)));
        check("R7 ready back", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 third valid", 64'(out_valid), 64'd1);
        check("R7 third result", 64'(got()), 64'(model(32'hC0400000, 1'b0)));
        @(negedge clk);
        check("R7 held operand taken once", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule